// File: doc/BRIEF.md
# Masked Sticky Interrupt Aggregator

This block collects a wide vector of internal interrupt event pulses into one interrupt request line. Each source is gated by a bit of a mask register. When a gated event arrives, it sets a sticky monitor bit. That bit stays set until software clears it, or until a dedicated clear input wipes the whole monitor at once. The request is active whenever at least one monitor bit is set, so several sources can be pending together. Software reads the monitor back one byte at a time to find out which sources fired.

The request line leaves the block as a data value plus an output enable, which together drive an external tri-state pad buffer. A 2-bit mode register selects one of four drive styles. Two of them are open-drain, either active low or active high, and float when idle. The other two are push-pull, with either polarity. The mask, mode and clear controls are plain write strobes with data. Any bus protocol sits outside this block.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous active-low reset, the mask register is all zeros, the mode register is 2'b00, every monitor bit is 0, and pin_oe and pin_data are both 0.
- R2: A mask write (mask_wr_en high) loads mask_wr_data at the clock edge. An event uses the mask value held before that edge, so an event arriving in the same cycle as a write that unmasks it is ignored.
- R3: A monitor bit becomes 1 in the cycle after its source pulses while its mask bit is 1. Events on masked sources leave their monitor bits unchanged.
- R4: A set monitor bit stays set after its source returns to 0. It also stays set after its mask bit is cleared.
- R5: A clear write (clr_wr_en high) clears at the next edge every monitor bit whose clr_wr_data bit is 1. Bits whose clr_wr_data bit is 0 keep their value.
- R6: If a gated event and a clear (per-bit or clr_all) reach the same bit in the same cycle, the event wins and the bit is 1 afterwards.
- R7: While clr_all is high, every monitor bit that has no gated event in that cycle becomes 0 at the next edge.
- R8: The request is active exactly when at least one monitor bit is 1. This is observed through pin_oe and pin_data.
- R9: A mode write (mode_wr_en high) loads mode_wr_data at the clock edge. The pin outputs follow the new mode from the next cycle.
- R10: Mode 2'b00: pin_data is 0, and pin_oe equals the request (drives low when active, floats when idle).
- R11: Mode 2'b01: pin_data is 1, and pin_oe equals the request (drives high when active, floats when idle).
- R12: Mode 2'b10: pin_oe is 1, and pin_data equals the request.
- R13: Mode 2'b11: pin_oe is 1, and pin_data is the inverse of the request.
- R14: rd_byte combinationally presents monitor bits [8*rd_idx+7 : 8*rd_idx]. Index 0 is the least significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 64 | Interrupt event pulses, one bit per source |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 64 | New mask value, 1 enables a source |
| mode_wr_en | input | 1 | Mode register write strobe |
| mode_wr_data | input | 2 | New pin drive mode |
| clr_wr_en | input | 1 | Per-bit monitor clear strobe |
| clr_wr_data | input | 64 | Write-1-to-clear monitor bits |
| clr_all | input | 1 | Clears the whole monitor |
| rd_idx | input | 3 | Monitor byte selector |
| rd_byte | output | 8 | Selected monitor byte |
| pin_data | output | 1 | Value for the pad buffer |
| pin_oe | output | 1 | Output enable for the pad buffer |

## Verification
The two actions that can collide on the same cycle are a gated event setting a monitor bit and a clear of that same bit, whether by a per-bit clear write or by clr_all. Directed steps place an event and a clear on the same bit in one cycle, and also place clr_all next to an event on a different bit. The byte readback then has to show the event bit set and the other bits cleared. The random phase overlaps events, clear writes, clr_all and mask writes freely. A bench model applies the stated priority and judges each result. A same-cycle mask write with an event is also provoked, to confirm that the old mask decides.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
// Package irq_agg_pkg
// Shared pin-drive mode encoding for the interrupt aggregator.
// Assumes a 2-bit mode field whose codes are fixed by the requirements.
package irq_agg_pkg;
    typedef enum logic [1:0] {
        PIN_OD_ACT_LOW  = 2'b00,
        PIN_OD_ACT_HIGH = 2'b01,
        PIN_PP_ACT_HIGH = 2'b10,
        PIN_PP_ACT_LOW  = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/irq_ctrl_regs.sv
`timescale 1ns/1ps
// Module irq_ctrl_regs
// Holds the source mask and the pin drive mode. Both load on their
// write strobes at the clock edge.
// Assumes: synchronous active-low reset; the mask resets to all-disabled
// and the mode resets to the open-drain active-low style.
module irq_ctrl_regs
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr_en,
    input  logic [N_SRC-1:0] mask_wr_data,
    input  logic             mode_wr_en,
    input  logic [1:0]       mode_wr_data,
    output logic [N_SRC-1:0] mask_q,
    output pin_mode_e        mode_q
);

    // Mask register: replaced whole on each write
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_wr_en)
            mask_q <= mask_wr_data;
    end

    // Mode register: selects the pad drive style
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= PIN_OD_ACT_LOW;
        else if (mode_wr_en)
            mode_q <= pin_mode_e'(mode_wr_data);
    end

endmodule

// File: rtl/irq_sticky_bank.sv
`timescale 1ns/1ps
// Module irq_sticky_bank
// One sticky monitor flop per source. A gated event sets the bit. A
// per-bit write-1 clear or the global clear resets it. When both reach a
// bit in one cycle, the event wins.
// Assumes: events are single-cycle pulses; the mask comes from a register.
module irq_sticky_bank #(
    parameter int N_SRC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] mask,
    input  logic             clr_en,
    input  logic [N_SRC-1:0] clr_data,
    input  logic             clr_all,
    output logic [N_SRC-1:0] mon_q
);

    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] kill_vec;

    // Per-bit set and clear requests
    always_comb begin
        set_vec  = evt & mask;
        kill_vec = {N_SRC{clr_all}} | ({N_SRC{clr_en}} & clr_data);
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_bit
        // Sticky flag: set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                mon_q[g] <= 1'b0;
            else if (set_vec[g])
                mon_q[g] <= 1'b1;
            else if (kill_vec[g])
                mon_q[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_pin_shaper.sv
`timescale 1ns/1ps
// Module irq_pin_shaper
// Maps the request level and the drive mode onto pad data and enable.
// Assumes an external tri-state buffer that drives pin_data when pin_oe
// is 1 and floats otherwise. Purely combinational, fed only by flops.
module irq_pin_shaper
    import irq_agg_pkg::*;
(
    input  logic      req,
    input  pin_mode_e mode,
    output logic      pin_data,
    output logic      pin_oe
);

    // Drive-style decode
    always_comb begin
        unique case (mode)
            PIN_OD_ACT_LOW:  begin pin_oe = req;  pin_data = 1'b0; end
            PIN_OD_ACT_HIGH: begin pin_oe = req;  pin_data = 1'b1; end
            PIN_PP_ACT_HIGH: begin pin_oe = 1'b1; pin_data = req;  end
            PIN_PP_ACT_LOW:  begin pin_oe = 1'b1; pin_data = !req; end
            default:         begin pin_oe = 1'b0; pin_data = 1'b0; end
        endcase
    end

endmodule

// File: rtl/irq_byte_select.sv
`timescale 1ns/1ps
// Module irq_byte_select
// Splits a wide vector into bytes and returns the one picked by an index.
// Assumes WIDTH is a multiple of BYTE_W; byte 0 holds the LSBs.
module irq_byte_select #(
    parameter int WIDTH  = 64,
    parameter int BYTE_W = 8,
    localparam int NUM_B = WIDTH / BYTE_W,
    localparam int IDX_W = (NUM_B > 1) ? $clog2(NUM_B) : 1
) (
    input  logic [WIDTH-1:0]  vec,
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] byte_out
);

    logic [BYTE_W-1:0] lanes [NUM_B];

    for (genvar b = 0; b < NUM_B; b++) begin : g_lane
        assign lanes[b] = vec[b*BYTE_W +: BYTE_W];
    end

    // Byte multiplexer
    always_comb begin
        byte_out = '0;
        for (int k = 0; k < NUM_B; k++)
            if (idx == IDX_W'(k))
                byte_out = lanes[k];
    end

endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
// Module irq_aggregator (top)
// Gathers N_SRC masked event sources into sticky monitor bits. It raises a
// request while any bit is set and shapes that request for a tri-state pad.
// The monitor is read back one byte at a time.
// Assumes: synchronous active-low reset; single-cycle source pulses.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int BYTE_W = 8,
    localparam int NUM_B = N_SRC / BYTE_W,
    localparam int IDX_W = (NUM_B > 1) ? $clog2(NUM_B) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_evt,
    input  logic              mask_wr_en,
    input  logic [N_SRC-1:0]  mask_wr_data,
    input  logic              mode_wr_en,
    input  logic [1:0]        mode_wr_data,
    input  logic              clr_wr_en,
    input  logic [N_SRC-1:0]  clr_wr_data,
    input  logic              clr_all,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              pin_data,
    output logic              pin_oe
);

    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] mon_q;
    pin_mode_e        mode_q;
    logic             req;

    irq_ctrl_regs #(.N_SRC(N_SRC)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_wr_en   (mask_wr_en),
        .mask_wr_data (mask_wr_data),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .mask_q       (mask_q),
        .mode_q       (mode_q)
    );

    irq_sticky_bank #(.N_SRC(N_SRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (src_evt),
        .mask     (mask_q),
        .clr_en   (clr_wr_en),
        .clr_data (clr_wr_data),
        .clr_all  (clr_all),
        .mon_q    (mon_q)
    );

    // Request level: any pending monitor bit
    always_comb req = |mon_q;

    irq_pin_shaper u_pin (
        .req      (req),
        .mode     (mode_q),
        .pin_data (pin_data),
        .pin_oe   (pin_oe)
    );

    irq_byte_select #(.WIDTH(N_SRC), .BYTE_W(BYTE_W)) u_rd (
        .vec      (mon_q),
        .idx      (rd_idx),
        .byte_out (rd_byte)
    );

endmodule

// File: rtl/irq_aggregator_chk.sv
`timescale 1ns/1ps
// Module irq_aggregator_chk
// Temporal checks on the aggregator, bound to the top module. It watches
// the mask, mode and monitor state against the ports.
module irq_aggregator_chk #(
    parameter int N_SRC = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_evt,
    input logic [N_SRC-1:0] mask_q,
    input logic [N_SRC-1:0] mon_q,
    input logic [1:0]       mode_q,
    input logic             clr_wr_en,
    input logic [N_SRC-1:0] clr_wr_data,
    input logic             clr_all,
    input logic             pin_data,
    input logic             pin_oe
);

    logic [N_SRC-1:0] gated;
    assign gated = src_evt & mask_q;

    AST_EVENT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mon_q & $past(gated)) == $past(gated)));                 // R3
    AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mon_q & ~$past(mon_q) & ~$past(gated)) == '0));          // R2
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr_en && !clr_all) |=> ((mon_q & $past(mon_q)) == $past(mon_q))); // R4
    AST_W1C_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_en |=> ((mon_q & $past(clr_wr_data & ~gated)) == '0));       // R5
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all || clr_wr_en) |=> ((mon_q & $past(gated)) == $past(gated))); // R6
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && (gated == '0)) |=> (mon_q == '0));                      // R7
    AST_MODE_OD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b00) |-> (!pin_data && (pin_oe == (mon_q != '0))));    // R10
    AST_MODE_OD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b01) |-> (pin_data && (pin_oe == (mon_q != '0))));     // R11
    AST_MODE_PP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b10) |-> (pin_oe && (pin_data == (mon_q != '0))));     // R12
    AST_MODE_PP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b11) |-> (pin_oe && (pin_data == (mon_q == '0))));     // R13

endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_evt     (src_evt),
    .mask_q      (mask_q),
    .mon_q       (mon_q),
    .mode_q      (mode_q),
    .clr_wr_en   (clr_wr_en),
    .clr_wr_data (clr_wr_data),
    .clr_all     (clr_all),
    .pin_data    (pin_data),
    .pin_oe      (pin_oe)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
// Bench for irq_aggregator: directed corner cases followed by seeded
// random traffic, all compared against a cycle model kept in the bench.
module irq_aggregator_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_evt = '0;
    logic        mask_wr_en = 1'b0;
    logic [63:0] mask_wr_data = '0;
    logic        mode_wr_en = 1'b0;
    logic [1:0]  mode_wr_data = '0;
    logic        clr_wr_en = 1'b0;
    logic [63:0] clr_wr_data = '0;
    logic        clr_all = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic [7:0]  rd_byte;
    logic        pin_data;
    logic        pin_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [63:0] mask_m = '0;
    logic [63:0] mon_m  = '0;
    logic [1:0]  mode_m = '0;

    always #2 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
        .clr_all(clr_all), .rd_idx(rd_idx), .rd_byte(rd_byte),
        .pin_data(pin_data), .pin_oe(pin_oe)
    );

    // Expected pad outputs {oe, data} for a mode and request level
    function automatic logic [1:0] exp_pin(input logic [1:0] m, input logic r);
        case (m)
            2'b00:   return {r, 1'b0};
            2'b01:   return {r, 1'b1};
            2'b10:   return {1'b1, r};
            default: return {1'b1, !r};
        endcase
    endfunction

    // Next monitor value: the event wins over both kinds of clear
    function automatic logic [63:0] next_mon(input logic [63:0] mon,
            input logic [63:0] ev, input logic [63:0] msk, input logic cen,
            input logic [63:0] cdat, input logic call);
        logic [63:0] base;
        base = call ? 64'd0 : (cen ? (mon & ~cdat) : mon);
        return base | (ev & msk);
    endfunction

    task automatic tick();
        @(posedge clk);
        if (rst_n) begin
            mon_m = next_mon(mon_m, src_evt, mask_m, clr_wr_en, clr_wr_data, clr_all);
            if (mask_wr_en) mask_m = mask_wr_data;
            if (mode_wr_en) mode_m = mode_wr_data;
        end else begin
            mon_m = '0; mask_m = '0; mode_m = '0;
        end
        @(negedge clk);
        src_evt = '0; mask_wr_en = 0; mode_wr_en = 0; clr_wr_en = 0; clr_all = 0;
    endtask

    task automatic check_all(input string tag);
        logic [1:0] ep;
        string ptag;
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #0.1;
            n_checks++;
            if (rd_byte !== mon_m[i*8 +: 8]) begin
                n_fails++;
                $display("FAIL %s R14 byte %0d: got %h expected %h", tag, i, rd_byte, mon_m[i*8 +: 8]);
            end
        end
        ep = exp_pin(mode_m, |mon_m);
        case (mode_m)
            2'b00: ptag = "R10";
            2'b01: ptag = "R11";
            2'b10: ptag = "R12";
            default: ptag = "R13";
        endcase
        n_checks++;
        if ({pin_oe, pin_data} !== ep) begin
            n_fails++;
            $display("FAIL %s %s R8 pin {oe,data}: got %b expected %b", tag, ptag, {pin_oe, pin_data}, ep);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        tick(); tick(); tick();
        rst_n = 1'b1;
        check_all("R1");

        // R2: unmasking write and event in the same cycle -> ignored
        mask_wr_en = 1; mask_wr_data = 64'h0000_0000_0000_00FF; src_evt = 64'h1;
        tick(); check_all("R2");

        // R3: bits 0 and 5 gated in, bit 9 masked off
        src_evt = (64'd1 << 0) | (64'd1 << 5) | (64'd1 << 9);
        tick(); check_all("R3");

        // R4: hold when idle, then after the mask is cleared
        tick(); check_all("R4");
        mask_wr_en = 1; mask_wr_data = '0;
        tick(); check_all("R4");

        // R9: walk through all modes while the request is active
        for (int m = 0; m < 4; m++) begin
            mode_wr_en = 1; mode_wr_data = 2'(m);
            tick(); check_all("R9");
        end

        // R7: clear everything, then walk the modes with the request idle
        clr_all = 1;
        tick(); check_all("R7");
        for (int m = 0; m < 4; m++) begin
            mode_wr_en = 1; mode_wr_data = 2'(m);
            tick(); check_all("R9");
        end

        // R5: per-bit write-1 clear
        mask_wr_en = 1; mask_wr_data = '1;
        tick();
        src_evt = 64'h0000_00F0_0000_000F;
        tick(); check_all("R3");
        clr_wr_en = 1; clr_wr_data = 64'h0000_0010_0000_0001;
        tick(); check_all("R5");

        // R6: event and per-bit clear on the same bit
        src_evt = 64'h8; clr_wr_en = 1; clr_wr_data = 64'h8;
        tick(); check_all("R6");
        // R6: clr_all with an event on another bit
        src_evt = 64'h80; clr_all = 1;
        tick(); check_all("R6");

        // R14: top-byte placement
        src_evt = (64'd1 << 63) | (64'd1 << 56) | (64'd1 << 17);
        tick(); check_all("R14");

        // Random overlap of events, clears, mask and mode writes
        for (int c = 0; c < 600; c++) begin
            src_evt = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if ($urandom_range(7) == 0) begin
                mask_wr_en = 1; mask_wr_data = {$urandom, $urandom};
            end
            if ($urandom_range(5) == 0) begin
                clr_wr_en = 1; clr_wr_data = {$urandom, $urandom};
            end
            clr_all = ($urandom_range(39) == 0);
            if ($urandom_range(19) == 0) begin
                mode_wr_en = 1; mode_wr_data = 2'($urandom_range(3));
            end
            tick(); check_all("R3 R4 R5 R6");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule